// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Upper-Byte Holding Latches

This block keeps the fetch address of a processor whose instructions are 16-bit words stored in byte-addressed program memory. The counter is 21 bits wide, always even, and steps by two for each sequential fetch. Only its least significant byte is reachable from the register bus. The two upper bytes are reached through two holding latches: one for bits 15:8 and a narrower one for bits 20:16.

A register-bus write of the low byte moves both latches into the upper counter bits in the same cycle. This gives computed jumps anywhere in the 2 MB space. A register-bus read of the low byte copies the upper counter bits back into the latches. Direct jumps (call, relative call, goto, branch) load the whole address at once and never touch the latches. Any change of flow raises a one-cycle discard indication, so the already-fetched word can be thrown away.

Top module: `pc_latch_unit`

## Requirements
- R1: While reset (rstN low) is held, and in the first cycle after it is released, the counter reads 0 and discardFetch is 0. Both latches also clear to 0 on reset, so the first low-byte write after reset sets bits 20:8 to 0.
- R2: A cycle with incEn high, and neither jumpEn nor lowWrEn high, adds 2 to the counter at the next clock edge. The sum wraps modulo 2^21, so 0x1FFFFE steps to 0x000000.
- R3: Bit 0 of pcOut is always 0. Bit 0 of jumpTarget and bit 0 of lowWrData are ignored.
- R4: jumpEn loads the counter with jumpTarget (bit 0 cleared) at the next edge. The contents of the latches have no effect on this load.
- R5: lowWrEn loads the counter at the next edge with {upper latch, high latch, lowWrData}, where the upper latch fills bits 20:16 and the high latch fills bits 15:8. The latch values used are those held before that edge.
- R6: Writing a latch (hiLatWrEn or upLatWrEn) leaves pcOut unchanged. The written value is seen only through a later low-byte write.
- R7: lowRdData always shows pcOut[7:0]. A cycle with lowRdEn high copies pcOut[15:8] into the high latch and pcOut[20:16] into the upper latch at the next edge.
- R8: Update priority is jump, then low-byte write, then increment. Only the highest-priority request present in a cycle takes effect.
- R9: If a latch write and lowRdEn occur in the same cycle, the written value wins for that latch. The other latch still takes the refresh.
- R10: discardFetch is 1 for exactly the cycle that follows a jump or a low-byte write. Otherwise it is 0.
- R11: In a cycle with none of incEn, jumpEn and lowWrEn high, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| incEn | input | 1 | Sequential step request (+2) |
| jumpEn | input | 1 | Direct full-address load request |
| jumpTarget | input | 21 | Direct load address |
| lowWrEn | input | 1 | Register-bus write of the low byte |
| lowWrData | input | 8 | Low-byte write value |
| lowRdEn | input | 1 | Register-bus read of the low byte (refreshes latches) |
| lowRdData | output | 8 | Current low byte of the counter |
| hiLatWrEn | input | 1 | Write strobe of the high latch |
| hiLatWrData | input | 8 | High latch value (counter bits 15:8) |
| upLatWrEn | input | 1 | Write strobe of the upper latch |
| upLatWrData | input | 5 | Upper latch value (counter bits 20:16) |
| pcOut | output | 21 | Current fetch address |
| discardFetch | output | 1 | Drop the word fetched before a change of flow |

## Verification
The latches have no port of their own, so their contents can only be seen after a later low-byte write has copied them into the counter. The hardest cases are the read-back refresh and its collision with an explicit latch write. To reach them, the bench first jumps to a known address and then issues the read, on its own or together with a latch write. A low-byte write follows, and the bench checks bits 20:8 of the resulting counter against the expected mix of refreshed and written values. Priority is tested by raising two or three update requests in the same cycle.

// File: rtl/pc_pkg.sv
package pc_pkg;
  parameter int PC_W   = 21;
  parameter int BYTE_W = 8;
  localparam int UP_W  = PC_W - 2 * BYTE_W;
  localparam int STEP  = 2;

  typedef struct packed {
    logic loadJump;
    logic loadLow;
    logic stepInc;
    logic refreshLat;
    logic wrHi;
    logic wrUp;
  } pcStrobes_t;
endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       incEn,
  input  logic       jumpEn,
  input  logic       lowWrEn,
  input  logic       lowRdEn,
  input  logic       hiLatWrEn,
  input  logic       upLatWrEn,
  output pcStrobes_t strb,
  output logic       discardFetch
);
  logic flowChange;
  logic discardQ;

  always_comb begin
    strb            = '0;
    strb.loadJump   = jumpEn;
    strb.loadLow    = lowWrEn && !jumpEn;
    strb.stepInc    = incEn && !jumpEn && !lowWrEn;
    strb.refreshLat = lowRdEn;
    strb.wrHi       = hiLatWrEn;
    strb.wrUp       = upLatWrEn;
  end

  assign flowChange = jumpEn || lowWrEn;

  always_ff @(posedge clk) begin
    if (!rstN) discardQ <= 1'b0;
    else       discardQ <= flowChange;
  end

  assign discardFetch = discardQ;

  // R8
  upd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadJump, strb.loadLow, strb.stepInc}));

  // R10
  discard_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (jumpEn || lowWrEn) |=> discardFetch);

  // R10
  discard_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(jumpEn || lowWrEn) |=> !discardFetch);
endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobes_t        strb,
  input  logic [PC_W-1:0]   jumpTarget,
  input  logic [BYTE_W-1:0] lowWrData,
  input  logic [BYTE_W-1:0] hiLatWrData,
  input  logic [UP_W-1:0]   upLatWrData,
  output logic [PC_W-1:0]   pcOut,
  output logic [BYTE_W-1:0] lowRdData
);
  logic [PC_W-1:0]   pcQ, pcNext;
  logic [BYTE_W-1:0] hiLatQ;
  logic [UP_W-1:0]   upLatQ;

  always_comb begin
    pcNext = pcQ;
    if (strb.loadJump)
      pcNext = {jumpTarget[PC_W-1:1], 1'b0};
    else if (strb.loadLow)
      pcNext = {upLatQ, hiLatQ, lowWrData[BYTE_W-1:1], 1'b0};
    else if (strb.stepInc)
      pcNext = pcQ + PC_W'(STEP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ    <= '0;
      hiLatQ <= '0;
      upLatQ <= '0;
    end else begin
      pcQ <= pcNext;
      if (strb.wrHi)            hiLatQ <= hiLatWrData;
      else if (strb.refreshLat) hiLatQ <= pcQ[2*BYTE_W-1:BYTE_W];
      if (strb.wrUp)            upLatQ <= upLatWrData;
      else if (strb.refreshLat) upLatQ <= pcQ[PC_W-1:2*BYTE_W];
    end
  end

  assign pcOut     = pcQ;
  assign lowRdData = pcQ[BYTE_W-1:0];

  // R3
  pc_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcQ[0] == 1'b0);

  // R4
  jump_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadJump |=> pcQ[PC_W-1:1] == $past(jumpTarget[PC_W-1:1]));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepInc |=> pcQ == $past(pcQ) + PC_W'(STEP));

  // R5
  low_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLow |=> pcQ[PC_W-1:BYTE_W] == $past({upLatQ, hiLatQ}));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadJump || strb.loadLow || strb.stepInc) |=> $stable(pcQ));

  // R9
  hi_wr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHi |=> hiLatQ == $past(hiLatWrData));
endmodule

// File: rtl/pc_latch_unit.sv
module pc_latch_unit
  import pc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              incEn,
  input  logic              jumpEn,
  input  logic [PC_W-1:0]   jumpTarget,
  input  logic              lowWrEn,
  input  logic [BYTE_W-1:0] lowWrData,
  input  logic              lowRdEn,
  output logic [BYTE_W-1:0] lowRdData,
  input  logic              hiLatWrEn,
  input  logic [BYTE_W-1:0] hiLatWrData,
  input  logic              upLatWrEn,
  input  logic [UP_W-1:0]   upLatWrData,
  output logic [PC_W-1:0]   pcOut,
  output logic              discardFetch
);
  pcStrobes_t strb;

  pc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .incEn        (incEn),
    .jumpEn       (jumpEn),
    .lowWrEn      (lowWrEn),
    .lowRdEn      (lowRdEn),
    .hiLatWrEn    (hiLatWrEn),
    .upLatWrEn    (upLatWrEn),
    .strb         (strb),
    .discardFetch (discardFetch)
  );

  pc_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .jumpTarget  (jumpTarget),
    .lowWrData   (lowWrData),
    .hiLatWrData (hiLatWrData),
    .upLatWrData (upLatWrData),
    .pcOut       (pcOut),
    .lowRdData   (lowRdData)
  );
endmodule

// File: tb/tb_pc_latch_unit.sv
module tb_pc_latch_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        incEn = 1'b0, jumpEn = 1'b0, lowWrEn = 1'b0, lowRdEn = 1'b0;
  logic        hiLatWrEn = 1'b0, upLatWrEn = 1'b0;
  logic [20:0] jumpTarget = '0;
  logic [7:0]  lowWrData = '0, hiLatWrData = '0;
  logic [4:0]  upLatWrData = '0;
  logic [7:0]  lowRdData;
  logic [20:0] pcOut;
  logic        discardFetch;

  int nChecks = 0;
  int nFails  = 0;

  pc_latch_unit dut (
    .clk(clk), .rstN(rstN), .incEn(incEn), .jumpEn(jumpEn),
    .jumpTarget(jumpTarget), .lowWrEn(lowWrEn), .lowWrData(lowWrData),
    .lowRdEn(lowRdEn), .lowRdData(lowRdData), .hiLatWrEn(hiLatWrEn),
    .hiLatWrData(hiLatWrData), .upLatWrEn(upLatWrEn),
    .upLatWrData(upLatWrData), .pcOut(pcOut), .discardFetch(discardFetch)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleAll();
    incEn = 0; jumpEn = 0; lowWrEn = 0; lowRdEn = 0;
    hiLatWrEn = 0; upLatWrEn = 0;
  endtask

  task automatic doJump(input logic [20:0] t);
    jumpEn = 1; jumpTarget = t; tick(); idleAll();
  endtask

  task automatic doLowWr(input logic [7:0] d);
    lowWrEn = 1; lowWrData = d; tick(); idleAll();
  endtask

  task automatic testReset();
    chk("R1 pc in reset", 32'(pcOut), 0);
    chk("R1 discard in reset", 32'(discardFetch), 0);
    rstN = 1;
    chk("R1 pc after release", 32'(pcOut), 0);
    doLowWr(8'hAB);
    chk("R1 latches cleared / R3 bit0", 32'(pcOut), 32'h0000AA);
  endtask

  task automatic testIncrement();
    tick();
    chk("R10 discard one cycle only", 32'(discardFetch), 0);
    incEn = 1; tick(); tick(); tick(); idleAll();
    chk("R2 three steps", 32'(pcOut), 32'h0000B0);
    chk("R2 no discard on step", 32'(discardFetch), 0);
    doJump(21'h1FFFFE);
    incEn = 1; tick(); idleAll();
    chk("R2 wrap", 32'(pcOut), 0);
  endtask

  task automatic testJump();
    hiLatWrEn = 1; hiLatWrData = 8'h12; upLatWrEn = 1; upLatWrData = 5'h05;
    tick(); idleAll();
    chk("R6 latch write keeps pc", 32'(pcOut), 0);
    doJump(21'h0ABCD1);
    chk("R4 jump ignores latches / R3", 32'(pcOut), 32'h0ABCD0);
    chk("R10 discard after jump", 32'(discardFetch), 1);
    tick();
    chk("R10 discard cleared", 32'(discardFetch), 0);
  endtask

  task automatic testLowWrite();
    hiLatWrEn = 1; hiLatWrData = 8'h34; upLatWrEn = 1; upLatWrData = 5'h1A;
    tick(); idleAll();
    chk("R6 latch write keeps pc", 32'(pcOut), 32'h0ABCD0);
    doLowWr(8'h57);
    chk("R5 latch copy", 32'(pcOut), 32'h1A3456);
    chk("R10 discard after low write", 32'(discardFetch), 1);
  endtask

  task automatic testReadRefresh();
    doJump(21'h0F9E10);
    chk("R7 read data", 32'(lowRdData), 32'h10);
    lowRdEn = 1; tick(); idleAll();
    chk("R11 read keeps pc", 32'(pcOut), 32'h0F9E10);
    doLowWr(8'h22);
    chk("R7 refresh latches", 32'(pcOut), 32'h0F9E22);
    chk("R7 read data follows", 32'(lowRdData), 32'h22);
  endtask

  task automatic testCollision();
    lowRdEn = 1; hiLatWrEn = 1; hiLatWrData = 8'h77; tick(); idleAll();
    doLowWr(8'h00);
    chk("R9 write beats refresh", 32'(pcOut), 32'h0F7700);
  endtask

  task automatic testPriority();
    jumpEn = 1; jumpTarget = 21'h012344; lowWrEn = 1; lowWrData = 8'hEE; incEn = 1;
    tick(); idleAll();
    chk("R8 jump first", 32'(pcOut), 32'h012344);
    lowWrEn = 1; lowWrData = 8'h60; incEn = 1; tick(); idleAll();
    chk("R8 low write over step", 32'(pcOut), 32'h0F7760);
  endtask

  task automatic testHold();
    tick(); tick(); tick();
    chk("R11 idle hold", 32'(pcOut), 32'h0F7760);
    chk("R10 idle no discard", 32'(discardFetch), 0);
  endtask

  initial begin
    fork
      begin
        tick(); tick();
        testReset();
        testIncrement();
        testJump();
        testLowWrite();
        testReadRefresh();
        testCollision();
        testPriority();
        testHold();
      end
      begin
        #(200000 * 8);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule